// File: doc/BRIEF.md
# Secure Monitor Call Trap Router

This block is one registered stage that decides what a processor does with a secure-monitor-call instruction. It runs in a 32-bit core that has four exception levels. Each cycle it can accept one valid-tagged instruction word. The word comes with a select for its encoding: the fixed 32-bit form or the two-halfword form. It also comes with the context needed to resolve it. That context is the current exception level, the security state, the condition flags, IT-block position, a hypervisor trap enable, two alternative monitor-call disable bits, and a flag giving the execution width of the monitor level.

One cycle later the stage reports a single outcome as a one-hot vector, together with a 16-bit syndrome immediate. The possible outcomes are: not this instruction, condition failed, undefined, no-operation, trap to EL2, or call to EL3. A static configuration input selects how the disabled call in Secure state is resolved. Raising the exception and decoding other instructions happen elsewhere.

Top module: `smc_trap_router`

## Requirements
- R1: In the fixed form (`isTwoHalf`=0), a word is recognised only when bits 31:28 are not 4'hF, bits 27:20 equal 8'h16 and bits 7:4 equal 4'h7. Bits 19:8 and bits 3:0 do not affect recognition. Any other word reports not-this-instruction (outcome bit 0).
- R2: In the two-halfword form (`isTwoHalf`=1), the first halfword is held in bits 31:16 and the second in bits 15:0. A word is recognised when bits 31:20 equal 12'hF7F and bits 15:12 equal 4'b1000. Bits 11:0 are should-be-zero bits and are not checked.
- R3: The condition is evaluated before any other rule, and a failing condition reports condition-failed (bit 1). The flags are packed as `condFlags`={N,Z,C,V}, and the usual 4-bit condition codes 0..14 apply. The fixed form takes its condition from bits 31:28. The two-halfword form takes `itCond` inside an IT block and always passes outside one.
- R4: A recognised instruction whose condition passes, issued at EL0, reports undefined (bit 2).
- R5: In the two-halfword form, an instruction inside an IT block that is not the last one in the block reports undefined. The last instruction of a block is not affected by this rule.
- R6: If the hypervisor trap enable is 1 and the instruction runs at Non-secure EL1, the outcome is trap to EL2 (bit 4), whatever the disable bits hold. The trap is not taken in Secure state or at EL2.
- R7: When the monitor level is 64-bit, only `monDisable64` is used. A value of 1 gives undefined. A value of 0 gives call to EL3 (bit 5) with a syndrome of all zeros, and `monDisable32` is ignored.
- R8: When the monitor level is 32-bit and `monDisable32` is 1, the outcome is undefined in Non-secure state. In Secure state it is NOP (bit 3) if `secureDisableNop` is 1 and undefined otherwise. `monDisable64` is ignored in this case.
- R9: In every other case at EL1 or higher, the outcome is call to EL3. For trap and call outcomes under a 32-bit monitor, the syndrome is the zero-extended 4-bit immediate: bits 3:0 in the fixed form, bits 19:16 in the two-halfword form. For all other outcomes the syndrome is zero.
- R10: The outputs follow the accepted input by exactly one clock. `outValid` copies `inValid`. While `outValid` is 1, exactly one outcome bit is set; while it is 0, the outcome is zero.
- R11: A synchronous active-high reset clears `outValid` and the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction word valid |
| instrWord | input | 32 | Instruction word |
| isTwoHalf | input | 1 | 1 = two-halfword form, 0 = fixed 32-bit form |
| excLevel | input | 2 | Current exception level, 0..3 |
| secureState | input | 1 | 1 = Secure |
| condFlags | input | 4 | {N,Z,C,V} |
| inItBlock | input | 1 | Instruction lies in an IT block |
| lastInItBlock | input | 1 | Instruction is the last one of its IT block |
| itCond | input | 4 | Condition applied by the IT block |
| hypTrapEn | input | 1 | Hypervisor trap enable for monitor calls |
| monDisable32 | input | 1 | Monitor call disable used with a 32-bit monitor |
| monDisable64 | input | 1 | Monitor call disable used with a 64-bit monitor |
| monitorIs64 | input | 1 | Monitor level executes 64-bit |
| secureDisableNop | input | 1 | Secure disabled call resolves to NOP (1) or undefined (0) |
| outValid | output | 1 | Outcome valid |
| outcome | output | 6 | One-hot: 0 not-this, 1 cond-fail, 2 undef, 3 NOP, 4 trap EL2, 5 call EL3 |
| syndromeImm | output | 16 | Syndrome immediate |

## Verification
The bench probes the priority boundaries. Three cases check the hypervisor trap against the disable bits: with both disable bits set, with Secure state, and at EL2. A router with the wrong order would report undefined there, or would trap where it should not. The bench swaps the width of the monitor level against the two disable bits, which exposes a design that reads the wrong bit. It also checks that a 64-bit monitor zeroes the syndrome and that a 32-bit monitor passes the immediate through. Failing conditions are combined with otherwise undefined contexts, so a design that tests the condition late reports undefined instead of condition-failed. Words with condition 4'hF, broken fixed bits or nonzero should-be-zero bits expose a decoder that is too loose or too strict.

// File: rtl/smc_router_pkg.sv
package smc_router_pkg;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 4;
  localparam int SYN_W   = 16;
  localparam int OUT_W   = 6;

  localparam int O_NOTSMC = 0;
  localparam int O_CONDF  = 1;
  localparam int O_UNDEF  = 2;
  localparam int O_NOP    = 3;
  localparam int O_TRAP2  = 4;
  localparam int O_CALL3  = 5;

  typedef struct packed {
    logic             isMatch;
    logic             condPass;
    logic             itFault;
    logic [IMM_W-1:0] imm;
  } decode_t;

  typedef struct packed {
    logic loadImm;
    logic zeroImm;
  } strobe_t;
endpackage

// File: rtl/smc_router_datapath.sv
module smc_router_datapath
  import smc_router_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic               isTwoHalf,
  input  logic [3:0]         condFlags,
  input  logic               inItBlock,
  input  logic               lastInItBlock,
  input  logic [3:0]         itCond,
  input  strobe_t            stb,
  output decode_t            dec,
  output logic [SYN_W-1:0]   synReg
);
  localparam logic [7:0]  A_OPC  = 8'h16;
  localparam logic [3:0]  A_LOW  = 4'h7;
  localparam logic [11:0] T_HI   = 12'hF7F;
  localparam logic [3:0]  T_SEC  = 4'b1000;

  function automatic logic evalCond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, r;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c[3:1])
      3'd0:    r = z;
      3'd1:    r = cy;
      3'd2:    r = n;
      3'd3:    r = v;
      3'd4:    r = cy & ~z;
      3'd5:    r = (n == v);
      3'd6:    r = ~z & (n == v);
      default: r = 1'b1;
    endcase
    if (c[0] && c != 4'hF) r = ~r;
    return r;
  endfunction

  logic armMatch, thumbMatch;
  logic [3:0] effCond;

  always_comb begin
    armMatch   = (instrWord[31:28] != 4'hF) && (instrWord[27:20] == A_OPC) &&
                 (instrWord[7:4] == A_LOW);
    thumbMatch = (instrWord[31:20] == T_HI) && (instrWord[15:12] == T_SEC);
    effCond    = isTwoHalf ? (inItBlock ? itCond : 4'hE) : instrWord[31:28];
    dec.isMatch  = isTwoHalf ? thumbMatch : armMatch;
    dec.condPass = evalCond(effCond, condFlags);
    dec.itFault  = isTwoHalf && inItBlock && !lastInItBlock;
    dec.imm      = isTwoHalf ? instrWord[19:16] : instrWord[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst)
      synReg <= '0;
    else if (stb.loadImm && !stb.zeroImm)
      synReg <= {{(SYN_W-IMM_W){1'b0}}, dec.imm};
    else
      synReg <= '0;
  end

  p_zero_imm_r7: assert property (@(posedge clk) disable iff (rst)
    stb.zeroImm |=> synReg == '0);
endmodule

// File: rtl/smc_router_ctrl.sv
module smc_router_ctrl
  import smc_router_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  decode_t          dec,
  input  logic [1:0]       excLevel,
  input  logic             secureState,
  input  logic             hypTrapEn,
  input  logic             monDisable32,
  input  logic             monDisable64,
  input  logic             monitorIs64,
  input  logic             secureDisableNop,
  output strobe_t          stb,
  output logic             outValid,
  output logic [OUT_W-1:0] outcome
);
  logic [OUT_W-1:0] nextOut;
  logic             nsEl1;

  always_comb begin
    nsEl1   = (excLevel == 2'd1) && !secureState;
    nextOut = '0;
    if (!dec.isMatch)                nextOut[O_NOTSMC] = 1'b1;
    else if (!dec.condPass)          nextOut[O_CONDF]  = 1'b1;
    else if (excLevel == 2'd0)       nextOut[O_UNDEF]  = 1'b1;
    else if (dec.itFault)            nextOut[O_UNDEF]  = 1'b1;
    else if (hypTrapEn && nsEl1)     nextOut[O_TRAP2]  = 1'b1;
    else if (monitorIs64) begin
      if (monDisable64)              nextOut[O_UNDEF]  = 1'b1;
      else                           nextOut[O_CALL3]  = 1'b1;
    end else if (monDisable32) begin
      if (secureState && secureDisableNop) nextOut[O_NOP] = 1'b1;
      else                           nextOut[O_UNDEF]  = 1'b1;
    end else                         nextOut[O_CALL3]  = 1'b1;

    stb.loadImm = inValid && (nextOut[O_TRAP2] || nextOut[O_CALL3]);
    stb.zeroImm = inValid && monitorIs64;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outcome  <= '0;
    end else begin
      outValid <= inValid;
      outcome  <= inValid ? nextOut : '0;
    end
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    outValid |-> $countones(outcome) == 1);
  p_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> outcome == '0);
  p_latency_r10: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_cond_first_r3: assert property (@(posedge clk) disable iff (rst)
    (inValid && dec.isMatch && !dec.condPass) |=> outcome[O_CONDF]);
  p_el0_r4: assert property (@(posedge clk) disable iff (rst)
    (inValid && dec.isMatch && dec.condPass && excLevel == 2'd0) |=> outcome[O_UNDEF]);
  p_trap_r6: assert property (@(posedge clk) disable iff (rst)
    (inValid && dec.isMatch && dec.condPass && !dec.itFault && hypTrapEn &&
     excLevel == 2'd1 && !secureState) |=> outcome[O_TRAP2]);
  p_nop_secure_r8: assert property (@(posedge clk) disable iff (rst)
    (outValid && outcome[O_NOP]) |-> $past(secureState));
endmodule

// File: rtl/smc_trap_router.sv
module smc_trap_router
  import smc_router_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [31:0] instrWord,
  input  logic        isTwoHalf,
  input  logic [1:0]  excLevel,
  input  logic        secureState,
  input  logic [3:0]  condFlags,
  input  logic        inItBlock,
  input  logic        lastInItBlock,
  input  logic [3:0]  itCond,
  input  logic        hypTrapEn,
  input  logic        monDisable32,
  input  logic        monDisable64,
  input  logic        monitorIs64,
  input  logic        secureDisableNop,
  output logic        outValid,
  output logic [5:0]  outcome,
  output logic [15:0] syndromeImm
);
  decode_t dec;
  strobe_t stb;

  smc_router_datapath i_dp (
    .clk(clk), .rst(rst), .instrWord(instrWord), .isTwoHalf(isTwoHalf),
    .condFlags(condFlags), .inItBlock(inItBlock), .lastInItBlock(lastInItBlock),
    .itCond(itCond), .stb(stb), .dec(dec), .synReg(syndromeImm)
  );

  smc_router_ctrl i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .dec(dec), .excLevel(excLevel),
    .secureState(secureState), .hypTrapEn(hypTrapEn), .monDisable32(monDisable32),
    .monDisable64(monDisable64), .monitorIs64(monitorIs64),
    .secureDisableNop(secureDisableNop), .stb(stb), .outValid(outValid),
    .outcome(outcome)
  );

  p_syn_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outcome[O_TRAP2] && !outcome[O_CALL3]) |-> syndromeImm == '0);
endmodule

// File: tb/test_smc_trap_router.sv
module test_smc_trap_router;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [31:0] instrWord = '0;
  logic isTwoHalf = 1'b0;
  logic [1:0] excLevel = 2'd1;
  logic secureState = 1'b0;
  logic [3:0] condFlags = '0;
  logic inItBlock = 1'b0, lastInItBlock = 1'b0;
  logic [3:0] itCond = 4'hE;
  logic hypTrapEn = 1'b0, monDisable32 = 1'b0, monDisable64 = 1'b0;
  logic monitorIs64 = 1'b0, secureDisableNop = 1'b0;
  logic outValid;
  logic [5:0] outcome;
  logic [15:0] syndromeImm;

  int checks = 0;
  int failures = 0;

  localparam logic [5:0] E_NOT = 6'b000001, E_CF = 6'b000010, E_UND = 6'b000100,
                         E_NOP = 6'b001000, E_TRP = 6'b010000, E_CAL = 6'b100000;
  localparam logic [31:0] A_SMC = 32'hE160_0070;
  localparam logic [31:0] T_SMC = 32'hF7F0_8000;

  always #10 clk = ~clk;

  smc_trap_router i_smc_trap_router (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic defaults();
    isTwoHalf = 0; excLevel = 2'd1; secureState = 0; condFlags = 0;
    inItBlock = 0; lastInItBlock = 0; itCond = 4'hE; hypTrapEn = 0;
    monDisable32 = 0; monDisable64 = 0; monitorIs64 = 0; secureDisableNop = 0;
  endtask

  task automatic run(string req, logic [31:0] word, logic [5:0] expOut, logic [15:0] expSyn);
    @(negedge clk);
    instrWord = word; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check({req, " valid"}, {31'd0, outValid}, 32'd1);
    check({req, " outcome"}, {26'd0, outcome}, {26'd0, expOut});
    check({req, " syndrome"}, {16'd0, syndromeImm}, {16'd0, expSyn});
  endtask

  task automatic t_reset();
    check("R11 reset valid", {31'd0, outValid}, 32'd0);
    check("R11 reset outcome", {26'd0, outcome}, 32'd0);
  endtask

  task automatic t_fixed_decode();
    defaults();
    run("R1 basic", A_SMC | 32'h5, E_CAL, 16'h5);
    run("R1 ignored bits", A_SMC | 32'h000F_FF0A, E_CAL, 16'hA);
    run("R1 cond 1111", 32'hF160_0070, E_NOT, 16'h0);
    run("R1 opcode bit", A_SMC ^ 32'h0010_0000, E_NOT, 16'h0);
    run("R1 low field", A_SMC ^ 32'h0000_0010, E_NOT, 16'h0);
  endtask

  task automatic t_two_half();
    defaults(); isTwoHalf = 1;
    run("R2 basic", T_SMC | 32'h0003_0000, E_CAL, 16'h3);
    run("R2 sbz ignored", T_SMC | 32'h000C_0ABC, E_CAL, 16'hC);
    run("R2 second half", T_SMC ^ 32'h0000_4000, E_NOT, 16'h0);
    run("R2 first half", T_SMC ^ 32'h0100_0000, E_NOT, 16'h0);
  endtask

  task automatic t_condition();
    defaults();
    run("R3 EQ fail", 32'h0160_0070, E_CF, 16'h0);
    condFlags = 4'b0100;
    run("R3 EQ pass", 32'h0160_0071, E_CAL, 16'h1);
    condFlags = 4'b1000;
    run("R3 GT fail", 32'hC160_0070, E_CF, 16'h0);
    condFlags = 4'b0010;
    run("R3 HI pass", 32'h8160_0072, E_CAL, 16'h2);
    condFlags = 4'b0000; excLevel = 2'd0;
    run("R3 before EL0", 32'h0160_0070, E_CF, 16'h0);
    defaults(); isTwoHalf = 1; inItBlock = 1; lastInItBlock = 0; itCond = 4'h0;
    run("R3 it cond before R5", T_SMC, E_CF, 16'h0);
  endtask

  task automatic t_el0();
    defaults(); excLevel = 2'd0; hypTrapEn = 1;
    run("R4 EL0", A_SMC, E_UND, 16'h0);
  endtask

  task automatic t_it_block();
    defaults(); isTwoHalf = 1; inItBlock = 1; lastInItBlock = 0;
    run("R5 not last", T_SMC | 32'h0001_0000, E_UND, 16'h0);
    lastInItBlock = 1;
    run("R5 last", T_SMC | 32'h0001_0000, E_CAL, 16'h1);
    defaults(); inItBlock = 1;
    run("R5 fixed form", A_SMC | 32'h1, E_CAL, 16'h1);
  endtask

  task automatic t_hyp_trap();
    defaults(); hypTrapEn = 1; monDisable32 = 1; monDisable64 = 1;
    run("R6 trap over disables", A_SMC | 32'h9, E_TRP, 16'h9);
    secureState = 1; monDisable32 = 0; monDisable64 = 0;
    run("R6 secure no trap", A_SMC | 32'h9, E_CAL, 16'h9);
    secureState = 0; excLevel = 2'd2;
    run("R6 EL2 no trap", A_SMC | 32'h9, E_CAL, 16'h9);
  endtask

  task automatic t_mon64();
    defaults(); monitorIs64 = 1; monDisable32 = 1;
    run("R7 call zero syn", A_SMC | 32'h7, E_CAL, 16'h0);
    monDisable64 = 1; monDisable32 = 0;
    run("R7 disabled", A_SMC | 32'h7, E_UND, 16'h0);
  endtask

  task automatic t_mon32();
    defaults(); monDisable32 = 1;
    run("R8 NS disabled", A_SMC, E_UND, 16'h0);
    secureState = 1; secureDisableNop = 1;
    run("R8 secure NOP", A_SMC | 32'h4, E_NOP, 16'h0);
    secureDisableNop = 0;
    run("R8 secure undef", A_SMC | 32'h4, E_UND, 16'h0);
    defaults(); monDisable64 = 1; excLevel = 2'd3;
    run("R8 disable64 ignored", A_SMC | 32'hE, E_CAL, 16'hE);
  endtask

  task automatic t_timing();
    defaults();
    @(negedge clk);
    check("R10 idle valid", {31'd0, outValid}, 32'd0);
    check("R10 idle outcome", {26'd0, outcome}, 32'd0);
    instrWord = A_SMC | 32'h6; inValid = 1;
    @(posedge clk); #1;
    check("R10 one cycle", {31'd0, outValid}, 32'd1);
    check("R9 syndrome call", {16'd0, syndromeImm}, 32'h6);
    @(negedge clk); inValid = 0;
    @(negedge clk);
    check("R10 drops", {31'd0, outValid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_fixed_decode();
    t_two_half();
    t_condition();
    t_el0();
    t_it_block();
    t_hyp_trap();
    t_mon64();
    t_mon32();
    t_timing();
    @(negedge clk);
    instrWord = A_SMC; inValid = 1; rst = 1;
    @(negedge clk);
    inValid = 0;
    check("R11 reset wins", {31'd0, outValid}, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule